// File: doc/BRIEF.md
# JTAG Instruction Privilege Gate

This block sits between the instruction shift stage of a test access port and the logic that picks a data register. It holds one of four access levels and checks every instruction loaded at Update-IR against the set that the current level permits. A permitted instruction becomes the active instruction. A refused one is replaced by BYPASS, and a sticky violation flag is set. At the highest level the port is shut: only BYPASS can be active, and the serial output is driven low with its enable off.

The level is held in an authorization register. A trusted authentication path, shown here as a load strobe with a two-bit value, writes this register. A write is taken only while the TAP is in Test-Logic-Reset or Run-Test/Idle. The TAP state machine is outside the block. It supplies state and Update-IR strobes as plain inputs. The held instruction is checked again against the level on every cycle. A level change therefore takes effect at once on an instruction that is already loaded.

Top module: `jtag_priv_gate`

## Requirements
- R1: After reset the level is 3 (locked), the active instruction is BYPASS (all ones, 4'hF by default) and the violation flag is 0.
- R2: BYPASS loaded at Update-IR is accepted at every level and never sets the violation flag.
- R3: At level 0 (open) every opcode loaded at Update-IR becomes the active instruction, including unassigned codes.
- R4: At level 1 (low) only the circuit-function opcode 4'h4, the firmware-upload opcode 4'h3 and BYPASS are accepted.
- R5: At level 2 (medium) only the boundary-drive opcode 4'h0, the pin-sample opcode 4'h1 and BYPASS are accepted.
- R6: At level 3 every non-BYPASS opcode is refused, and tdo_o and tdo_en_o are 0 in every cycle. At the other levels they follow tdo_core_i and tdo_core_en_i in the same cycle.
- R7: A refused opcode gives BYPASS as the active instruction one clock after Update-IR and sets viol_o. viol_o then stays 1 until reset.
- R8: A level load takes effect one clock later, and only when tap_reset_i or tap_idle_i is high. In any other cycle the load is ignored.
- R9: If a level change makes the held instruction not permitted, ir_active_o shows BYPASS from the cycle the new level takes effect.
- R10: tap_reset_i high sets the active instruction to BYPASS on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tap_reset_i | input | 1 | TAP is in Test-Logic-Reset |
| tap_idle_i | input | 1 | TAP is in Run-Test/Idle |
| update_ir_i | input | 1 | Update-IR strobe |
| ir_shift_i | input | IR_W | Instruction from the shift stage |
| lvl_load_i | input | 1 | Level write strobe from the authentication path |
| lvl_data_i | input | 2 | Level to write |
| tdo_core_i | input | 1 | Serial data from the selected register |
| tdo_core_en_i | input | 1 | Output enable from the TAP |
| ir_active_o | output | IR_W | Active, filtered instruction |
| level_o | output | 2 | Current access level |
| viol_o | output | 1 | Sticky refused-instruction flag |
| tdo_o | output | 1 | Gated serial output |
| tdo_en_o | output | 1 | Gated output enable |

## Verification
The bench uses the default parameters: a 4-bit instruction, BYPASS as all ones, and the boundary, sample, firmware and circuit opcodes at 0, 1, 3 and 4. Because the width is small, unassigned opcodes such as 4'h9 can be driven directly. This covers every level's accept set and every refusal boundary. Mid-run resets clear the sticky flag, so the bench can observe a violation at each level separately. It also drives level loads outside the allowed TAP states to check that they are ignored.

// File: rtl/privgate_pkg.sv
package privgate_pkg;
  localparam int unsigned LVL_W   = 2;
  localparam int unsigned NUM_LVL = 1 << LVL_W;

  typedef enum logic [LVL_W-1:0] {
    PL_OPEN = 2'd0,
    PL_LOW  = 2'd1,
    PL_MED  = 2'd2,
    PL_LOCK = 2'd3
  } priv_lvl_e;
endpackage

// File: rtl/privgate_level_reg.sv
module privgate_level_reg
  import privgate_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  logic      window_i,
  input  priv_lvl_e lvl_i,
  output priv_lvl_e lvl_o
);
  // start locked
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 lvl_o <= PL_LOCK;
    else if (load_i && window_i) lvl_o <= lvl_i;
  end
endmodule

// File: rtl/privgate_perm_table.sv
module privgate_perm_table
  import privgate_pkg::*;
#(
  parameter int unsigned     IR_W       = 4,
  parameter logic [IR_W-1:0] OP_EXTEST  = 4'h0,
  parameter logic [IR_W-1:0] OP_SAMPLE  = 4'h1,
  parameter logic [IR_W-1:0] OP_FWLOAD  = 4'h3,
  parameter logic [IR_W-1:0] OP_CIRC    = 4'h4,
  parameter logic [IR_W-1:0] OP_BYPASS  = '1
) (
  input  logic [IR_W-1:0] op_i,
  input  priv_lvl_e       lvl_i,
  output logic            ok_o
);
  logic [NUM_LVL-1:0] ok_by_lvl;
  logic is_byp, is_ext, is_smp, is_fw, is_circ;

  assign is_byp  = (op_i == OP_BYPASS);
  assign is_ext  = (op_i == OP_EXTEST);
  assign is_smp  = (op_i == OP_SAMPLE);
  assign is_fw   = (op_i == OP_FWLOAD);
  assign is_circ = (op_i == OP_CIRC);

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    if (g == int'(PL_OPEN)) begin : g_open
      assign ok_by_lvl[g] = 1'b1;
    end else if (g == int'(PL_LOW)) begin : g_low
      assign ok_by_lvl[g] = is_byp | is_fw | is_circ;
    end else if (g == int'(PL_MED)) begin : g_med
      assign ok_by_lvl[g] = is_byp | is_ext | is_smp;
    end else begin : g_lock
      assign ok_by_lvl[g] = is_byp;
    end
  end

  assign ok_o = ok_by_lvl[lvl_i];
endmodule

// File: rtl/privgate_ir_hold.sv
module privgate_ir_hold #(
  parameter int unsigned     IR_W      = 4,
  parameter logic [IR_W-1:0] OP_BYPASS = '1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tap_reset_i,
  input  logic            update_i,
  input  logic [IR_W-1:0] op_i,
  input  logic            op_ok_i,
  output logic [IR_W-1:0] ir_q_o,
  output logic            viol_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q_o <= OP_BYPASS;
      viol_o <= 1'b0;
    end else if (tap_reset_i) begin
      ir_q_o <= OP_BYPASS;
    end else if (update_i) begin
      if (op_ok_i) begin
        ir_q_o <= op_i;
      end else begin
        ir_q_o <= OP_BYPASS;
        viol_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/privgate_tdo_guard.sv
module privgate_tdo_guard
  import privgate_pkg::*;
(
  input  priv_lvl_e lvl_i,
  input  logic      tdo_i,
  input  logic      tdo_en_i,
  output logic      tdo_o,
  output logic      tdo_en_o
);
  logic shut;
  assign shut     = (lvl_i == PL_LOCK);
  assign tdo_o    = shut ? 1'b0 : tdo_i;
  assign tdo_en_o = shut ? 1'b0 : tdo_en_i;
endmodule

// File: rtl/jtag_priv_gate.sv
module jtag_priv_gate
  import privgate_pkg::*;
#(
  parameter int unsigned     IR_W      = 4,
  parameter logic [IR_W-1:0] OP_EXTEST = 4'h0,
  parameter logic [IR_W-1:0] OP_SAMPLE = 4'h1,
  parameter logic [IR_W-1:0] OP_FWLOAD = 4'h3,
  parameter logic [IR_W-1:0] OP_CIRC   = 4'h4,
  parameter logic [IR_W-1:0] OP_BYPASS = '1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tap_reset_i,
  input  logic            tap_idle_i,
  input  logic            update_ir_i,
  input  logic [IR_W-1:0] ir_shift_i,
  input  logic            lvl_load_i,
  input  logic [LVL_W-1:0] lvl_data_i,
  input  logic            tdo_core_i,
  input  logic            tdo_core_en_i,
  output logic [IR_W-1:0] ir_active_o,
  output logic [LVL_W-1:0] level_o,
  output logic            viol_o,
  output logic            tdo_o,
  output logic            tdo_en_o
);
  priv_lvl_e       lvl_q;
  logic            new_ok, held_ok;
  logic [IR_W-1:0] ir_q;

  privgate_level_reg u_level (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (lvl_load_i),
    .window_i (tap_reset_i | tap_idle_i),
    .lvl_i    (priv_lvl_e'(lvl_data_i)),
    .lvl_o    (lvl_q)
  );

  // incoming instruction vs. current level
  privgate_perm_table #(
    .IR_W(IR_W), .OP_EXTEST(OP_EXTEST), .OP_SAMPLE(OP_SAMPLE),
    .OP_FWLOAD(OP_FWLOAD), .OP_CIRC(OP_CIRC), .OP_BYPASS(OP_BYPASS)
  ) u_perm_new (
    .op_i  (ir_shift_i),
    .lvl_i (lvl_q),
    .ok_o  (new_ok)
  );

  privgate_ir_hold #(.IR_W(IR_W), .OP_BYPASS(OP_BYPASS)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tap_reset_i (tap_reset_i),
    .update_i    (update_ir_i),
    .op_i        (ir_shift_i),
    .op_ok_i     (new_ok),
    .ir_q_o      (ir_q),
    .viol_o      (viol_o)
  );

  // held instruction re-checked after a level change
  privgate_perm_table #(
    .IR_W(IR_W), .OP_EXTEST(OP_EXTEST), .OP_SAMPLE(OP_SAMPLE),
    .OP_FWLOAD(OP_FWLOAD), .OP_CIRC(OP_CIRC), .OP_BYPASS(OP_BYPASS)
  ) u_perm_held (
    .op_i  (ir_q),
    .lvl_i (lvl_q),
    .ok_o  (held_ok)
  );

  privgate_tdo_guard u_tdo (
    .lvl_i    (lvl_q),
    .tdo_i    (tdo_core_i),
    .tdo_en_i (tdo_core_en_i),
    .tdo_o    (tdo_o),
    .tdo_en_o (tdo_en_o)
  );

  assign ir_active_o = held_ok ? ir_q : OP_BYPASS;
  assign level_o     = lvl_q;
endmodule

// File: rtl/privgate_chk.sv
module privgate_chk #(
  parameter int unsigned     IR_W      = 4,
  parameter logic [IR_W-1:0] OP_EXTEST = 4'h0,
  parameter logic [IR_W-1:0] OP_SAMPLE = 4'h1,
  parameter logic [IR_W-1:0] OP_BYPASS = '1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tap_reset_i,
  input logic            tap_idle_i,
  input logic            update_ir_i,
  input logic [IR_W-1:0] ir_shift_i,
  input logic            lvl_load_i,
  input logic [1:0]      lvl_data_i,
  input logic            tdo_core_i,
  input logic            tdo_core_en_i,
  input logic [IR_W-1:0] ir_active_o,
  input logic [1:0]      level_o,
  input logic            viol_o,
  input logic            tdo_o,
  input logic            tdo_en_o
);
  AST_LVL_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tap_reset_i && !tap_idle_i) |=> $stable(level_o)); // R8
  AST_LOCK_TDO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == 2'd3) |-> (!tdo_o && !tdo_en_o)); // R6
  AST_LOCK_IR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == 2'd3) |-> (ir_active_o == OP_BYPASS)); // R6
  AST_MED_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == 2'd2) |-> (ir_active_o == OP_BYPASS || ir_active_o == OP_EXTEST
                           || ir_active_o == OP_SAMPLE)); // R5
  AST_VIOL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> viol_o); // R7
  AST_BYP_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_ir_i && ir_shift_i == OP_BYPASS && !viol_o) |=> !viol_o); // R2
  AST_TLR_BYP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_reset_i |=> (ir_active_o == OP_BYPASS)); // R10
endmodule

bind jtag_priv_gate privgate_chk #(
  .IR_W(IR_W), .OP_EXTEST(OP_EXTEST), .OP_SAMPLE(OP_SAMPLE), .OP_BYPASS(OP_BYPASS)
) u_chk (.*);

// File: tb/jtag_priv_gate_test.sv
module jtag_priv_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int IR_W = 4;

  typedef struct {
    logic [3:0] ir;
    logic [1:0] lvl;
    logic       viol;
    logic       tdo;
    logic       tdo_en;
    string      tag;
  } exp_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tap_reset = 0, tap_idle = 0, upd = 0, ld = 0, tdo_c = 0, tdo_ce = 0;
  logic [3:0] ir_sh = '0;
  logic [1:0] ldat = '0;
  logic [3:0] ir_act;
  logic [1:0] lvl;
  logic viol, tdo, tdo_en;

  int checks = 0, failures = 0;
  bit done = 0;
  exp_t q[$];
  logic [1:0] m_lvl;
  logic [3:0] m_ir;
  logic m_viol;

  always #(CLK_PERIOD/2) clk = ~clk;

  jtag_priv_gate uut (
    .clk_i(clk), .rst_ni(rst_ni), .tap_reset_i(tap_reset), .tap_idle_i(tap_idle),
    .update_ir_i(upd), .ir_shift_i(ir_sh), .lvl_load_i(ld), .lvl_data_i(ldat),
    .tdo_core_i(tdo_c), .tdo_core_en_i(tdo_ce), .ir_active_o(ir_act),
    .level_o(lvl), .viol_o(viol), .tdo_o(tdo), .tdo_en_o(tdo_en)
  );

  function automatic bit permit(logic [1:0] l, logic [3:0] op);
    case (l)
      2'd0:    return 1'b1;
      2'd1:    return op == 4'h4 || op == 4'h3 || op == 4'hF;
      2'd2:    return op == 4'h0 || op == 4'h1 || op == 4'hF;
      default: return op == 4'hF;
    endcase
  endfunction

  task automatic compare(exp_t e);
    checks++;
    if (ir_act !== e.ir || lvl !== e.lvl || viol !== e.viol ||
        tdo !== e.tdo || tdo_en !== e.tdo_en) begin
      failures++;
      $display("FAIL %s: ir=%h lvl=%0d viol=%b tdo=%b en=%b exp ir=%h lvl=%0d viol=%b tdo=%b en=%b",
               e.tag, ir_act, lvl, viol, tdo, tdo_en, e.ir, e.lvl, e.viol, e.tdo, e.tdo_en);
    end
  endtask

  // monitor
  initial forever begin
    @(posedge clk); #1;
    if (q.size() > 0) compare(q.pop_front());
  end

  task automatic step(bit tr, bit idl, bit up, logic [3:0] op, bit l, logic [1:0] ld_v,
                      bit td, bit tde, string tag);
    exp_t e;
    logic [1:0] old_lvl;
    @(negedge clk);
    tap_reset = tr; tap_idle = idl; upd = up; ir_sh = op; ld = l; ldat = ld_v;
    tdo_c = td; tdo_ce = tde;
    old_lvl = m_lvl;
    if (l && (tr || idl)) m_lvl = ld_v;
    if (tr) m_ir = 4'hF;
    else if (up) begin
      if (permit(old_lvl, op)) m_ir = op;
      else begin m_ir = 4'hF; m_viol = 1'b1; end
    end
    e.ir = permit(m_lvl, m_ir) ? m_ir : 4'hF;
    e.lvl = m_lvl; e.viol = m_viol;
    e.tdo = (m_lvl == 2'd3) ? 1'b0 : td;
    e.tdo_en = (m_lvl == 2'd3) ? 1'b0 : tde;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic do_reset();
    exp_t e;
    @(negedge clk);
    rst_ni = 0; tap_reset = 0; tap_idle = 0; upd = 0; ld = 0; tdo_c = 1; tdo_ce = 1;
    #1;
    m_lvl = 2'd3; m_ir = 4'hF; m_viol = 0;
    e.ir = 4'hF; e.lvl = 2'd3; e.viol = 0; e.tdo = 0; e.tdo_en = 0; e.tag = "R1 reset";
    compare(e);
    @(negedge clk); rst_ni = 1;
  endtask

  task automatic set_level(logic [1:0] v, string tag);
    step(0, 1, 0, 4'h0, 1, v, 1, 1, tag);
  endtask

  task automatic upd_ir(logic [3:0] op, string tag);
    step(0, 0, 1, op, 0, 2'd0, 1, 1, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_lvl = 2'd3; m_ir = 4'hF; m_viol = 0;
    repeat (2) @(negedge clk);
    do_reset();
    // locked level
    upd_ir(4'hF, "R2 bypass at locked");
    step(0, 0, 0, 4'h0, 1, 2'd0, 1, 1, "R8 load outside window ignored");
    step(0, 0, 0, 4'h0, 0, 2'd0, 1, 0, "R6 tdo held low when locked");
    upd_ir(4'h0, "R6 R7 boundary opcode refused at locked");
    upd_ir(4'h1, "R7 flag stays set");
    do_reset();
    // open level
    set_level(2'd0, "R8 load in idle");
    step(0, 0, 0, 4'h0, 0, 2'd0, 1, 0, "R6 tdo follows when open");
    upd_ir(4'h6, "R3 flash opcode at open");
    upd_ir(4'h9, "R3 unassigned opcode at open");
    upd_ir(4'h5, "R3 register opcode at open");
    set_level(2'd2, "R9 held opcode masked after level change");
    upd_ir(4'h0, "R5 boundary opcode at medium");
    upd_ir(4'h1, "R5 sample opcode at medium");
    upd_ir(4'hF, "R2 bypass at medium");
    upd_ir(4'h3, "R5 R7 firmware opcode refused at medium");
    do_reset();
    // low level through Test-Logic-Reset window
    step(1, 0, 0, 4'h0, 1, 2'd1, 0, 1, "R8 R10 load in reset state");
    upd_ir(4'h4, "R4 circuit opcode at low");
    upd_ir(4'h3, "R4 firmware opcode at low");
    step(1, 0, 0, 4'h0, 0, 2'd0, 1, 1, "R10 reset state clears instruction");
    upd_ir(4'hF, "R2 bypass at low");
    upd_ir(4'h0, "R4 R7 boundary opcode refused at low");
    upd_ir(4'h4, "R7 flag sticky after later accept");
    step(0, 1, 0, 4'h0, 1, 2'd3, 1, 1, "R6 R9 relock hides instruction and tdo");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule